// File: doc/BRIEF.md
# Real-Time Calendar Core with Update Cycle and Wildcard Alarm

This block is a calendar clock. It keeps seconds, minutes, hours, day of week, date, month, year and century. It advances the fields once per second, counting ticks of a slow timebase that arrives as a one-cycle enable (`tick_i`) on the system clock. Each field is stored internally as a binary number. It is re-encoded on the way out, so the host can choose BCD or plain binary, and 12-hour or 24-hour hours, at any moment. The host writes a field through a byte-wide load port, in whatever encoding is selected when it writes.

Within each second, a sub-second phase counter decides when the update happens. During the last few ticks before the update, it raises an update-in-progress indication, so that software reading the time knows to wait. Every update produces a one-cycle update pulse, and the new time appears in that same cycle. An alarm built from a seconds, a minutes and an hours byte is compared against the new time. Any of those three bytes can be a wildcard. A matching alarm produces an alarm pulse in the same cycle as the update pulse.

A three-bit divider control selects one of three states: running, halted, or held in reset. When the divider leaves reset, the first update comes half a second later. A set-mode input freezes the fields so that software can write a consistent time. The phase counter keeps running through set mode, so counting resumes on the same sub-second alignment.

Top module: `rtc_clock_core`

## Requirements
- R1: With `bin_mode_i`=1 every time byte is the plain binary value. With `bin_mode_i`=0 it is two BCD digits: tens in bits [7:4] and units in [3:0].
- R2: With `h24_mode_i`=0 the hour byte shows 1..12. Hour 0 shows as 12 and hour 12 shows as 12. Bit 7 is set for hours 12..23. With `h24_mode_i`=1 the hour byte shows 0..23 and bit 7 is clear.
- R3: Seconds carry into minutes, minutes into hours and hours into the date. The date rolls over at the month length: 30 for months 4, 6, 9 and 11, and 31 for the other months except February. February has 29 days when the year is divisible by 4 and 28 otherwise.
- R4: Day of week runs 1..7 and wraps from 7 to 1. Month runs 1..12, and the step from 12 to 1 carries into the year. Year 99 wraps to 0 and carries into the century, which wraps from 99 to 0. After reset the time is 00:00:00, day of week 1, date 1, month 1, year 0, century 0.
- R5: While the divider runs (`div_sel_i` ≤ 3'b010), `upd_o` is high for one cycle every `TICKS` ticks. `time_o` shows the new time in that same cycle.
- R6: `uip_o` is high during the last `UIP_TICKS` ticks before each update and low for the rest of the second.
- R7: While `set_mode_i`=1 the fields do not advance, `uip_o` stays 0 and `alarm_o` stays 0. Writes through the load port still take effect.
- R8: When `div_sel_i[2:1]`=2'b11, there are no update pulses, no alarm pulses and no UIP. When the divider moves from that state to a running setting, the first update comes after `TICKS`/2 ticks.
- R9: Set mode does not disturb the sub-second phase. Update pulses keep their cadence during set mode. After set mode is left, the next update adds one second to the loaded values.
- R10: `alarm_o` pulses in the same cycle as `upd_o` when the encoded new seconds, minutes and hour bytes equal the non-wildcard alarm bytes. It stays low when any non-wildcard byte differs.
- R11: An alarm byte whose bits [7:6] are 2'b11 matches every value of its field.
- R12: A write with `ld_we_i`=1 replaces one field. The field is picked by `ld_sel_i`: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 century. The byte is decoded in the current encoding, and the new value is visible on the next cycle. Field n sits in `time_o[8n+7:8n]`.
- R13: When `div_sel_i` is 3'b011, 3'b100 or 3'b101, the phase is frozen: no pulses occur and the time is stable. On returning to a running setting, counting continues from the frozen phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase tick enable |
| set_mode_i | input | 1 | Freeze fields for writing |
| bin_mode_i | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| h24_mode_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| div_sel_i | input | 3 | Divider control: run, halt or reset |
| ld_we_i | input | 1 | Field write strobe |
| ld_sel_i | input | 3 | Field selector for a write |
| ld_data_i | input | 8 | Encoded byte to write |
| alarm_sec_i | input | 8 | Alarm seconds byte or wildcard |
| alarm_min_i | input | 8 | Alarm minutes byte or wildcard |
| alarm_hour_i | input | 8 | Alarm hour byte or wildcard |
| time_o | output | 64 | Eight encoded time bytes, seconds in the low byte |
| uip_o | output | 1 | Update-in-progress window |
| upd_o | output | 1 | One-cycle update-ended pulse |
| alarm_o | output | 1 | One-cycle alarm pulse |

## Verification
A wrong carry or a wrong month length stays hidden until the update that crosses that boundary. At that update it shows on `time_o` in the same cycle as `upd_o`. For that reason, each calendar vector is loaded one second before the boundary it tests. A phase counter that is off by even one tick moves both the `uip_o` edge and the `upd_o` pulse by a whole cycle. The bench therefore counts cycles exactly: from one update to the next, and from a divider release to the first update. A corrupted mode or alarm decode changes at once the bytes seen at the ports, or whether `alarm_o` fires next to the next `upd_o`.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int FIELDS   = 8;
    localparam int FW       = 7;
    localparam int HOUR_IDX = 2;

    typedef logic [FW-1:0] fld_t;

    typedef struct packed {
        fld_t cen;
        fld_t yr;
        fld_t mon;
        fld_t dom;
        fld_t dow;
        fld_t hour;
        fld_t min;
        fld_t sec;
    } cal_t;

    typedef enum logic [2:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HOUR = 3'd2,
        F_DOW  = 3'd3,
        F_DOM  = 3'd4,
        F_MON  = 3'd5,
        F_YR   = 3'd6,
        F_CEN  = 3'd7
    } fsel_e;

    function automatic logic [7:0] enc_val(input fld_t v, input logic bin);
        logic [3:0] tens;
        logic [3:0] ones;
        tens = 4'(v / 7'd10);
        ones = 4'(v % 7'd10);
        return bin ? {1'b0, v} : {tens, ones};
    endfunction

    function automatic fld_t dec_val(input logic [7:0] b, input logic bin);
        fld_t bcd;
        bcd = fld_t'({3'b000, b[7:4]} * 7'd10 + {3'b000, b[3:0]});
        return bin ? b[6:0] : bcd;
    endfunction

    function automatic logic [7:0] enc_hour(input fld_t h, input logic bin, input logic h24);
        fld_t h12;
        logic pm;
        pm = (h >= 7'd12);
        if (h == 7'd0)
            h12 = 7'd12;
        else if (h > 7'd12)
            h12 = h - 7'd12;
        else
            h12 = h;
        return h24 ? enc_val(h, bin) : (enc_val(h12, bin) | {pm, 7'b0});
    endfunction

    function automatic fld_t dec_hour(input logic [7:0] b, input logic bin, input logic h24);
        fld_t h12;
        fld_t base;
        h12  = dec_val({1'b0, b[6:0]}, bin);
        base = (h12 == 7'd12) ? 7'd0 : h12;
        if (h24)
            return dec_val(b, bin);
        return b[7] ? base + 7'd12 : base;
    endfunction

    function automatic fld_t days_in(input fld_t mon, input fld_t yr);
        fld_t d;
        case (mon)
            7'd2:                      d = (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:   d = 7'd30;
            default:                   d = 7'd31;
        endcase
        return d;
    endfunction

    function automatic logic alarm_ok(input logic [7:0] al, input logic [7:0] val);
        return (al[7:6] == 2'b11) || (al == val);
    endfunction

endpackage

// File: rtl/rtc_phase.sv
module rtc_phase #(
    parameter int TICKS     = 32768,
    parameter int UIP_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [2:0] div_i,
    output logic       upd_stb_o,
    output logic       upd_pulse_o,
    output logic       win_o
);
    localparam int PW = $clog2(TICKS);
    localparam logic [PW-1:0] LAST = PW'(TICKS - 1);
    localparam logic [PW-1:0] HALF = PW'(TICKS / 2);
    localparam logic [PW-1:0] WIN  = PW'(TICKS - UIP_TICKS);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic          was_rst;
        logic          upd;
    } ph_t;

    ph_t ph_d, ph_q;
    logic div_rst, div_run, stb;

    always_comb begin
        div_rst = (div_i[2:1] == 2'b11);
        div_run = (div_i <= 3'b010);
        stb     = tick_i && div_run && !ph_q.was_rst && (ph_q.phase == LAST);
        ph_d     = ph_q;
        ph_d.upd = stb;
        if (div_rst) begin
            ph_d.phase   = '0;
            ph_d.was_rst = 1'b1;
        end else if (div_run) begin
            if (ph_q.was_rst) begin
                ph_d.phase   = HALF;
                ph_d.was_rst = 1'b0;
            end else if (tick_i) begin
                ph_d.phase = (ph_q.phase == LAST) ? '0 : ph_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ph_q <= '0;
        else
            ph_q <= ph_d;
    end

    assign upd_stb_o   = stb;
    assign upd_pulse_o = ph_q.upd;
    assign win_o       = div_run && !ph_q.was_rst && (ph_q.phase >= WIN);

    // R5
    upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse_o |=> !upd_pulse_o);

    // R6
    uip_before_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse_o |-> $past(win_o));

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i[2:1] == 2'b11) |=> !upd_pulse_o);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv_i,
    input  logic       ld_we_i,
    input  logic [2:0] ld_sel_i,
    input  logic [7:0] ld_byte_i,
    input  logic       bin_i,
    input  logic       h24_i,
    output cal_t       cal_q_o,
    output cal_t       cal_d_o
);
    cal_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (adv_i) begin
            if (c_q.sec >= 7'd59) begin
                c_d.sec = 7'd0;
                if (c_q.min >= 7'd59) begin
                    c_d.min = 7'd0;
                    if (c_q.hour >= 7'd23) begin
                        c_d.hour = 7'd0;
                        c_d.dow  = (c_q.dow >= 7'd7) ? 7'd1 : c_q.dow + 7'd1;
                        if (c_q.dom >= days_in(c_q.mon, c_q.yr)) begin
                            c_d.dom = 7'd1;
                            if (c_q.mon >= 7'd12) begin
                                c_d.mon = 7'd1;
                                if (c_q.yr >= 7'd99) begin
                                    c_d.yr  = 7'd0;
                                    c_d.cen = (c_q.cen >= 7'd99) ? 7'd0 : c_q.cen + 7'd1;
                                end else begin
                                    c_d.yr = c_q.yr + 7'd1;
                                end
                            end else begin
                                c_d.mon = c_q.mon + 7'd1;
                            end
                        end else begin
                            c_d.dom = c_q.dom + 7'd1;
                        end
                    end else begin
                        c_d.hour = c_q.hour + 7'd1;
                    end
                end else begin
                    c_d.min = c_q.min + 7'd1;
                end
            end else begin
                c_d.sec = c_q.sec + 7'd1;
            end
        end
        if (ld_we_i) begin
            case (fsel_e'(ld_sel_i))
                F_SEC:   c_d.sec  = dec_val(ld_byte_i, bin_i);
                F_MIN:   c_d.min  = dec_val(ld_byte_i, bin_i);
                F_HOUR:  c_d.hour = dec_hour(ld_byte_i, bin_i, h24_i);
                F_DOW:   c_d.dow  = dec_val(ld_byte_i, bin_i);
                F_DOM:   c_d.dom  = dec_val(ld_byte_i, bin_i);
                F_MON:   c_d.mon  = dec_val(ld_byte_i, bin_i);
                F_YR:    c_d.yr   = dec_val(ld_byte_i, bin_i);
                default: c_d.cen  = dec_val(ld_byte_i, bin_i);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.dow <= 7'd1;
            c_q.dom <= 7'd1;
            c_q.mon <= 7'd1;
        end else begin
            c_q <= c_d;
        end
    end

    assign cal_q_o = c_q;
    assign cal_d_o = c_d;

    // R3
    sec_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !ld_we_i) |=> (c_q.sec != $past(c_q.sec)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !ld_we_i) |=> (c_q == $past(c_q)));

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire_i,
    input  fld_t       nxt_sec_i,
    input  fld_t       nxt_min_i,
    input  fld_t       nxt_hour_i,
    input  logic       bin_i,
    input  logic       h24_i,
    input  logic [7:0] al_sec_i,
    input  logic [7:0] al_min_i,
    input  logic [7:0] al_hour_i,
    output logic       alarm_o
);
    logic hit_d, hit_q;

    always_comb begin
        hit_d = fire_i
             && alarm_ok(al_sec_i,  enc_val(nxt_sec_i, bin_i))
             && alarm_ok(al_min_i,  enc_val(nxt_min_i, bin_i))
             && alarm_ok(al_hour_i, enc_hour(nxt_hour_i, bin_i, h24_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hit_q <= 1'b0;
        else
            hit_q <= hit_d;
    end

    assign alarm_o = hit_q;

endmodule

// File: rtl/rtc_clock_core.sv
module rtc_clock_core
    import rtc_cal_pkg::*;
#(
    parameter int TICKS     = 32768,
    parameter int UIP_TICKS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        set_mode_i,
    input  logic        bin_mode_i,
    input  logic        h24_mode_i,
    input  logic [2:0]  div_sel_i,
    input  logic        ld_we_i,
    input  logic [2:0]  ld_sel_i,
    input  logic [7:0]  ld_data_i,
    input  logic [7:0]  alarm_sec_i,
    input  logic [7:0]  alarm_min_i,
    input  logic [7:0]  alarm_hour_i,
    output logic [63:0] time_o,
    output logic        uip_o,
    output logic        upd_o,
    output logic        alarm_o
);
    logic upd_stb, win, adv;
    cal_t cal_q, cal_d;
    fld_t fa [FIELDS];

    rtc_phase #(.TICKS(TICKS), .UIP_TICKS(UIP_TICKS)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .div_i       (div_sel_i),
        .upd_stb_o   (upd_stb),
        .upd_pulse_o (upd_o),
        .win_o       (win)
    );

    assign adv   = upd_stb && !set_mode_i;
    assign uip_o = win && !set_mode_i;

    rtc_calendar u_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (adv),
        .ld_we_i   (ld_we_i),
        .ld_sel_i  (ld_sel_i),
        .ld_byte_i (ld_data_i),
        .bin_i     (bin_mode_i),
        .h24_i     (h24_mode_i),
        .cal_q_o   (cal_q),
        .cal_d_o   (cal_d)
    );

    rtc_alarm u_alarm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (adv),
        .nxt_sec_i  (cal_d.sec),
        .nxt_min_i  (cal_d.min),
        .nxt_hour_i (cal_d.hour),
        .bin_i      (bin_mode_i),
        .h24_i      (h24_mode_i),
        .al_sec_i   (alarm_sec_i),
        .al_min_i   (alarm_min_i),
        .al_hour_i  (alarm_hour_i),
        .alarm_o    (alarm_o)
    );

    assign fa[0] = cal_q.sec;
    assign fa[1] = cal_q.min;
    assign fa[2] = cal_q.hour;
    assign fa[3] = cal_q.dow;
    assign fa[4] = cal_q.dom;
    assign fa[5] = cal_q.mon;
    assign fa[6] = cal_q.yr;
    assign fa[7] = cal_q.cen;

    generate
        for (genvar i = 0; i < FIELDS; i++) begin : g_enc
            if (i == HOUR_IDX) begin : g_hour
                assign time_o[8*i +: 8] = enc_hour(fa[i], bin_mode_i, h24_mode_i);
            end else begin : g_plain
                assign time_o[8*i +: 8] = enc_val(fa[i], bin_mode_i);
            end
        end
    endgenerate

    // R10
    alarm_with_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> upd_o);

endmodule

// File: tb/sim_rtc_clock_core.sv
module sim_rtc_clock_core;
    localparam int TICKS = 32;
    localparam int UIPT  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b1;
    logic        set_mode_i = 1'b0;
    logic        bin_mode_i = 1'b0;
    logic        h24_mode_i = 1'b1;
    logic [2:0]  div_sel_i = 3'b010;
    logic        ld_we_i = 1'b0;
    logic [2:0]  ld_sel_i = 3'd0;
    logic [7:0]  ld_data_i = 8'd0;
    logic [7:0]  alarm_sec_i = 8'h45;
    logic [7:0]  alarm_min_i = 8'hC0;
    logic [7:0]  alarm_hour_i = 8'hC0;
    logic [63:0] time_o;
    logic        uip_o, upd_o, alarm_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rtc_clock_core #(.TICKS(TICKS), .UIP_TICKS(UIPT)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .set_mode_i(set_mode_i),
        .bin_mode_i(bin_mode_i), .h24_mode_i(h24_mode_i), .div_sel_i(div_sel_i),
        .ld_we_i(ld_we_i), .ld_sel_i(ld_sel_i), .ld_data_i(ld_data_i),
        .alarm_sec_i(alarm_sec_i), .alarm_min_i(alarm_min_i), .alarm_hour_i(alarm_hour_i),
        .time_o(time_o), .uip_o(uip_o), .upd_o(upd_o), .alarm_o(alarm_o)
    );

    // dm, h24, start s m h dow dom mon yr cen, expected s m h dow dom mon yr cen
    localparam int NV = 9;
    localparam int VT [NV][18] = '{
        '{0,1, 59,59,23,7,31,12,99,19,  0, 0, 0,1, 1, 1, 0,20},
        '{1,1, 30,20,10,3,15, 6,24,20, 31,20,10,3,15, 6,24,20},
        '{0,0, 59,59,23,2,28, 2,24,20,  0, 0, 0,3,29, 2,24,20},
        '{0,1, 59,59,23,4,28, 2,23,20,  0, 0, 0,5, 1, 3,23,20},
        '{1,0, 59,59,23,5,30, 4,21,20,  0, 0, 0,6, 1, 5,21,20},
        '{0,1, 59,34,12,6,30, 9, 5,20,  0,35,12,6,30, 9, 5,20},
        '{0,0, 59,59,11,1,31, 1, 0,20,  0, 0,12,1,31, 1, 0,20},
        '{0,1, 59,59,23,7,31,12,99,99,  0, 0, 0,1, 1, 1, 0, 0},
        '{0,1, 59,59,23,3,29, 2,24,20,  0, 0, 0,4, 1, 3,24,20}
    };

    function automatic logic [7:0] enc(input int v, input bit dm);
        return dm ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] enc_h(input int h, input bit dm, input bit h24);
        int h12;
        if (h24) return enc(h, dm);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return enc(h12, dm) | ((h >= 12) ? 8'h80 : 8'h00);
    endfunction

    function automatic logic [63:0] pack(input int s, input int m, input int h, input int dw,
                                         input int dd, input int mo, input int y, input int c,
                                         input bit dm, input bit h24);
        return {enc(c, dm), enc(y, dm), enc(mo, dm), enc(dd, dm), enc(dw, dm),
                enc_h(h, dm, h24), enc(m, dm), enc(s, dm)};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic load(input int sel, input logic [7:0] b);
        ld_we_i = 1'b1; ld_sel_i = 3'(sel); ld_data_i = b;
        @(negedge clk);
        ld_we_i = 1'b0;
    endtask

    task automatic wait_upd(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!upd_o && n < 200);
        check(upd_o === 1'b1, "R5 update pulse arrives", {63'd0, upd_o}, 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [63:0] snap;
        bit bad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 reset values
        check(time_o === pack(0,0,0,1,1,1,0,0,0,1), "R4 reset time", time_o, pack(0,0,0,1,1,1,0,0,0,1));
        check({uip_o, upd_o, alarm_o} === 3'b000, "R4 reset outputs", {61'd0, uip_o, upd_o, alarm_o}, 64'd0);

        // R5 R6 cadence and UIP window
        wait_upd(n);
        for (int k = 1; k <= TICKS; k++) begin
            @(negedge clk);
            if (k == UIPT*2 || k == TICKS-UIPT-1 || k == TICKS-UIPT || k == TICKS-1 || k == TICKS)
                check(uip_o === (k >= TICKS-UIPT && k < TICKS), "R6 uip window",
                      {63'd0, uip_o}, {63'd0, (k >= TICKS-UIPT && k < TICKS)});
            if (k == TICKS-1 || k == TICKS)
                check(upd_o === (k == TICKS), "R5 update period",
                      {63'd0, upd_o}, {63'd0, k == TICKS});
        end

        // R1 R2 R3 R4 calendar table
        for (int i = 0; i < NV; i++) begin
            set_mode_i = 1'b1;
            bin_mode_i = VT[i][0][0];
            h24_mode_i = VT[i][1][0];
            @(negedge clk);
            for (int f = 0; f < 8; f++)
                load(f, (f == 2) ? enc_h(VT[i][4], VT[i][0][0], VT[i][1][0]) : enc(VT[i][2+f], VT[i][0][0]));
            set_mode_i = 1'b0;
            wait_upd(n);
            snap = pack(VT[i][10], VT[i][11], VT[i][12], VT[i][13], VT[i][14], VT[i][15],
                        VT[i][16], VT[i][17], VT[i][0][0], VT[i][1][0]);
            check(time_o === snap, "R1 R2 R3 R4 rollover vector", time_o, snap);
            check(alarm_o === 1'b0, "R10 no alarm on mismatch", {63'd0, alarm_o}, 64'd0);
        end

        // R12 load while running
        bin_mode_i = 1'b0; h24_mode_i = 1'b1;
        wait_upd(n);
        load(1, 8'h42);
        check(time_o[15:8] === 8'h42, "R12 minute load", {56'd0, time_o[15:8]}, 64'h42);

        // R10 R11 alarm
        set_mode_i = 1'b1;
        @(negedge clk);
        load(0, 8'h30); load(1, 8'h20); load(2, 8'h10);
        alarm_sec_i = 8'h31; alarm_min_i = 8'hC0; alarm_hour_i = 8'hC0;
        set_mode_i = 1'b0;
        wait_upd(n);
        check(alarm_o === 1'b1 && time_o[7:0] === 8'h31, "R11 wildcard minute and hour", {63'd0, alarm_o}, 64'd1);
        wait_upd(n);
        check(alarm_o === 1'b0, "R10 seconds mismatch", {63'd0, alarm_o}, 64'd0);
        alarm_sec_i = 8'h33; alarm_min_i = 8'h20; alarm_hour_i = 8'h10;
        wait_upd(n);
        check(alarm_o === 1'b1, "R10 exact match", {63'd0, alarm_o}, 64'd1);
        alarm_sec_i = 8'hC0; alarm_min_i = 8'hC0; alarm_hour_i = 8'h11;
        wait_upd(n);
        check(alarm_o === 1'b0, "R10 hour mismatch", {63'd0, alarm_o}, 64'd0);
        alarm_hour_i = 8'hC0;
        wait_upd(n);
        check(alarm_o === 1'b1, "R11 all wildcards", {63'd0, alarm_o}, 64'd1);

        // R7 R9 set mode keeps phase
        bad = 1'b0;
        for (int k = 1; k <= 2*TICKS; k++) begin
            @(negedge clk);
            if (k > 6 && k < 40 && uip_o) bad = 1'b1;
            if (k == TICKS) begin
                check(upd_o === 1'b1, "R9 cadence in set mode", {63'd0, upd_o}, 64'd1);
                check(alarm_o === 1'b0, "R7 no alarm in set mode", {63'd0, alarm_o}, 64'd0);
                check(time_o[7:0] === 8'h10, "R7 frozen loaded seconds", {56'd0, time_o[7:0]}, 64'h10);
            end
            if (k == 2*TICKS-1)
                check(upd_o === 1'b0, "R9 no early update", {63'd0, upd_o}, 64'd0);
            if (k == 2*TICKS) begin
                check(upd_o === 1'b1, "R9 update on old phase", {63'd0, upd_o}, 64'd1);
                check(time_o[7:0] === 8'h11, "R9 resume from loaded", {56'd0, time_o[7:0]}, 64'h11);
            end
            if (k == 5) begin
                set_mode_i = 1'b1; ld_we_i = 1'b1; ld_sel_i = 3'd0; ld_data_i = 8'h10;
            end
            if (k == 6) ld_we_i = 1'b0;
            if (k == 40) set_mode_i = 1'b0;
        end
        check(!bad, "R7 uip low in set mode", {63'd0, bad}, 64'd0);

        // R8 divider reset and half-second release
        div_sel_i = 3'b110;
        bad = 1'b0;
        snap = time_o;
        repeat (3*TICKS) begin
            @(negedge clk);
            if (upd_o || uip_o || alarm_o) bad = 1'b1;
        end
        check(!bad && time_o === snap, "R8 divider reset silences events", time_o, snap);
        div_sel_i = 3'b010;
        wait_upd(n);
        check(n == TICKS/2 + 1, "R8 first update after half second", 64'(n), 64'(TICKS/2 + 1));

        // R13 halted divider
        repeat (5) @(negedge clk);
        div_sel_i = 3'b011;
        bad = 1'b0;
        snap = time_o;
        repeat (3*TICKS) begin
            @(negedge clk);
            if (upd_o || alarm_o) bad = 1'b1;
        end
        check(!bad && time_o === snap, "R13 halt freezes time", time_o, snap);
        div_sel_i = 3'b010;
        wait_upd(n);
        check(n == TICKS-5, "R13 resume from frozen phase", 64'(n), 64'(TICKS-5));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule